// File: doc/BRIEF.md
# Table-Coded Serial Clock Divider

This block derives a serial shift clock from a faster input clock for a serial peripheral master. Software does not give a divide ratio directly. It gives a small index code, and the block looks up the ratio. A parameter selects one of two ladders.

The ladder variant takes a 5-bit code. Its ratios alternate between powers of two and one-and-a-half times a power of two, so some periods have an odd length. The binary variant takes a 3-bit code, and each step doubles the ratio starting from 4.

Besides the clock itself, the block drives two one-cycle strobes that tell the shift logic where the rising and the falling transitions are. An enable input freezes the divider in place. A code that is reserved, or above the configured top, parks the clock low and raises an error flag. A new code only takes effect when the running period ends.

Top module: `sclk_divider`

## Requirements
- R1: In ladder mode (TABLE_MODE=1), an even code c in 2..TOP_CODE gives a period of 2^(c/2+1) input cycles. An odd code c in 3..TOP_CODE gives a period of 3*2^((c-1)/2) input cycles. Code 18 gives 1024.
- R2: In binary mode (TABLE_MODE=0), the 3-bit code n gives a period of 4*2^n input cycles, from 4 to 512. The special input has no effect in this mode.
- R3: Each output period starts with sclk high. sclk stays high for floor(R/2) cycles and low for the remaining R-floor(R/2) cycles, so for an odd R the high phase is one cycle shorter.
- R4: leadStb is high for exactly the one cycle in which sclk has just risen. trailStb is high for exactly the one cycle in which sclk has just fallen. There is one of each per period, and sclk changes at no other time.
- R5: Code 0 is reserved. When it is sampled, sclk goes low and stays low, codeErr goes high, and no strobes occur.
- R6: In ladder mode, code 1 gives a period of 3 when specialEn is high. When specialEn is low, code 1 is treated as reserved, as in R5.
- R7: A code above TOP_CODE (16 or 18) is treated as reserved. With TOP_CODE=16, code 16 still gives 512.
- R8: The code is sampled only at a period boundary. A change made during a period leaves that period at the old ratio, and the next period uses the new one.
- R9: While enable is low, the position counter, sclk and the active ratio hold. No strobes occur, and each held cycle lengthens the current period by one.
- R10: After reset, sclk, leadStb, trailStb and codeErr are all low.
- R11: codeErr drops, and the clock restarts, at the first boundary where a legal code is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input (peripheral) clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Advances the divider when high |
| specialEn | input | 1 | Allows ladder code 1 (divide by 3) |
| code | input | CODE_W (5 or 3) | Divide-ratio index |
| sclk | output | 1 | Divided serial clock, idle low |
| leadStb | output | 1 | One-cycle strobe on each sclk rise |
| trailStb | output | 1 | One-cycle strobe on each sclk fall |
| codeErr | output | 1 | Sampled code is reserved or out of range |

## Verification
The ctrl module samples a code at the edge that closes a period. At that same edge the output register drives sclk high and pulses leadStb, so the first cycle of the new period is visible one register after the boundary. A code change is therefore due at the next boundary, not at once. The bench throws away the period that is in flight and only times the periods that follow.

Periods are measured at falling clock edges, from one leadStb to the next. The high phase and the trailing strobe are counted inside that window. Reserved codes are checked once a wait longer than the largest period has passed, so the boundary that samples them has surely arrived. The enable pause is counted as extra cycles of the period that contains it.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  localparam int RATIO_W = 11;
  typedef logic [RATIO_W-1:0] ratio_t;

  // Control-to-datapath strobes; at most one is high per cycle.
  typedef struct packed {
    logic startPeriod;
    logic haltIdle;
    logic fallEdge;
  } edgeCmd_t;

  // Ladder: even codes are powers of two, odd codes are 1.5x the step below.
  function automatic ratio_t ladderRatio(input logic [4:0] c);
    if (c[0]) return ratio_t'(3) << ((c - 5'd1) >> 1);
    else      return ratio_t'(1) << ((c >> 1) + 5'd1);
  endfunction

  function automatic ratio_t binaryRatio(input logic [2:0] n);
    return ratio_t'(4) << n;
  endfunction
endpackage

// File: rtl/sclk_code_decode.sv
module sclk_code_decode
  import sclk_div_pkg::*;
#(
  parameter bit TABLE_MODE = 1'b1,
  parameter int TOP_CODE   = 18,
  localparam int CODE_W    = TABLE_MODE ? 5 : 3
) (
  input  logic [CODE_W-1:0] code,
  input  logic              specialEn,
  output ratio_t            ratio,
  output logic              legal
);
  generate
    if (TABLE_MODE) begin : g_ladder
      always_comb begin
        ratio = ladderRatio(5'(code));
        legal = (code != '0) && (code != CODE_W'(1) || specialEn)
                && (32'(code) <= TOP_CODE);
      end
    end else begin : g_binary
      logic unusedSpecial;
      assign unusedSpecial = specialEn;
      always_comb begin
        ratio = binaryRatio(3'(code));
        legal = 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/sclk_div_ctrl.sv
module sclk_div_ctrl
  import sclk_div_pkg::*;
#(
  parameter bit TABLE_MODE = 1'b1,
  parameter int TOP_CODE   = 18,
  localparam int CODE_W    = TABLE_MODE ? 5 : 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              specialEn,
  input  logic [CODE_W-1:0] code,
  output edgeCmd_t          cmd
);
  ratio_t ratioQ, cntQ, cntNext, newRatio;
  logic   activeQ, newLegal, atBoundary;

  sclk_code_decode #(.TABLE_MODE(TABLE_MODE), .TOP_CODE(TOP_CODE)) decode_i (
    .code(code), .specialEn(specialEn), .ratio(newRatio), .legal(newLegal)
  );

  assign cntNext    = cntQ + ratio_t'(1);
  assign atBoundary = !activeQ || (cntQ == ratioQ - ratio_t'(1));

  always_comb begin
    cmd = '0;
    if (enable) begin
      if (atBoundary) begin
        cmd.startPeriod = newLegal;
        cmd.haltIdle    = !newLegal;
      end else begin
        cmd.fallEdge = (cntNext == (ratioQ >> 1));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ratioQ  <= '0;
      cntQ    <= '0;
      activeQ <= 1'b0;
    end else if (enable) begin
      if (atBoundary) begin
        cntQ    <= '0;
        activeQ <= newLegal;
        if (newLegal) ratioQ <= newRatio;
      end else begin
        cntQ <= cntNext;
      end
    end
  end

  // R8
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && !atBoundary) |=> $stable(ratioQ));
  // R9
  frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> ($stable(cntQ) && $stable(activeQ) && $stable(ratioQ)));
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    activeQ |-> (cntQ < ratioQ));
  // R4
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmd));
endmodule

// File: rtl/sclk_div_dp.sv
module sclk_div_dp
  import sclk_div_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  edgeCmd_t cmd,
  output logic     sclk,
  output logic     leadStb,
  output logic     trailStb,
  output logic     codeErr
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclk     <= 1'b0;
      leadStb  <= 1'b0;
      trailStb <= 1'b0;
      codeErr  <= 1'b0;
    end else begin
      leadStb  <= cmd.startPeriod;
      trailStb <= cmd.fallEdge;
      if (cmd.startPeriod) begin
        sclk    <= 1'b1;
        codeErr <= 1'b0;
      end else if (cmd.haltIdle) begin
        sclk    <= 1'b0;
        codeErr <= 1'b1;
      end else if (cmd.fallEdge) begin
        sclk <= 1'b0;
      end
    end
  end

  // R4
  lead_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    leadStb |-> $rose(sclk));
  // R4
  trail_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    trailStb |-> $fell(sclk));
  // R4
  edge_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclk) |-> (leadStb || trailStb));
  // R5
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeErr |-> (!sclk && !leadStb && !trailStb));
endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
  import sclk_div_pkg::*;
#(
  parameter bit TABLE_MODE = 1'b1,
  parameter int TOP_CODE   = 18,
  localparam int CODE_W    = TABLE_MODE ? 5 : 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              specialEn,
  input  logic [CODE_W-1:0] code,
  output logic              sclk,
  output logic              leadStb,
  output logic              trailStb,
  output logic              codeErr
);
  edgeCmd_t cmd;

  sclk_div_ctrl #(.TABLE_MODE(TABLE_MODE), .TOP_CODE(TOP_CODE)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .specialEn(specialEn),
    .code(code), .cmd(cmd)
  );

  sclk_div_dp dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sclk(sclk),
    .leadStb(leadStb), .trailStb(trailStb), .codeErr(codeErr)
  );

  // R10
  always_ff @(posedge clk) begin
    if (!rstN) reset_quiet_chk: assert (!sclk && !leadStb && !trailStb && !codeErr);
  end
endmodule

// File: tb/sclk_divider_tb_top.sv
`timescale 1ns/1ps
module sclk_divider_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic specialEn = 1'b0;
  logic [4:0] codeT = 5'd2;
  logic [4:0] code16 = 5'd2;
  logic [2:0] codeB = 3'd0;
  logic sclkT, leadT, trailT, errT;
  logic sclk16, lead16, trail16, err16;
  logic sclkB, leadB, trailB, errB;
  logic [2:0] sclkV, leadV, trailV, errV;
  int nChecks = 0;
  int nBad = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sclk_divider #(.TABLE_MODE(1'b1), .TOP_CODE(18)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .specialEn(specialEn), .code(codeT),
    .sclk(sclkT), .leadStb(leadT), .trailStb(trailT), .codeErr(errT));
  sclk_divider #(.TABLE_MODE(1'b1), .TOP_CODE(16)) dut16_i (
    .clk(clk), .rstN(rstN), .enable(enable), .specialEn(specialEn), .code(code16),
    .sclk(sclk16), .leadStb(lead16), .trailStb(trail16), .codeErr(err16));
  sclk_divider #(.TABLE_MODE(1'b0), .TOP_CODE(7)) dutBin_i (
    .clk(clk), .rstN(rstN), .enable(enable), .specialEn(specialEn), .code(codeB),
    .sclk(sclkB), .leadStb(leadB), .trailStb(trailB), .codeErr(errB));

  assign sclkV  = {sclkB, sclk16, sclkT};
  assign leadV  = {leadB, lead16, leadT};
  assign trailV = {trailB, trail16, trailT};
  assign errV   = {errB, err16, errT};

  function automatic int expRatio(input int sel, input int c, input bit sp);
    int top;
    if (sel == 2) return 4 * (2 ** c);
    top = (sel == 0) ? 18 : 16;
    if (c == 0 || c > top || (c == 1 && !sp)) return 0;
    if (c % 2 == 1) return 3 * (2 ** ((c - 1) / 2));
    return 2 ** (c / 2 + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setCode(input int sel, input int c);
    if (sel == 0) codeT = 5'(c);
    else if (sel == 1) code16 = 5'(c);
    else codeB = 3'(c);
  endtask

  task automatic measure(input int sel, output int hi, output int per, output int trails);
    int guard = 0;
    hi = 0; per = 0; trails = 0;
    while (!leadV[sel] && guard < 3000) begin
      guard++;
      @(negedge clk);
    end
    do begin
      if (sclkV[sel]) hi++;
      if (trailV[sel]) trails++;
      per++;
      @(negedge clk);
    end while (!leadV[sel] && per < 3000);
  endtask

  task automatic legalCase(input int sel, input int c, input bit sp, input string req);
    int hi, per, tr, r;
    r = expRatio(sel, c, sp);
    specialEn = sp;
    setCode(sel, c);
    measure(sel, hi, per, tr);
    measure(sel, hi, per, tr);
    check(per == r, req, per, r);
    check(hi == r / 2, "R3", hi, r / 2);
    check(tr == 1, "R4", tr, 1);
    check(errV[sel] == 1'b0, "R11", int'(errV[sel]), 0);
  endtask

  task automatic reservedCase(input int sel, input int c, input bit sp, input string req);
    int leads = 0;
    int highs = 0;
    specialEn = sp;
    setCode(sel, c);
    repeat (1030) @(negedge clk);
    check(errV[sel] == 1'b1, req, int'(errV[sel]), 1);
    repeat (20) begin
      if (leadV[sel] || trailV[sel]) leads++;
      if (sclkV[sel]) highs++;
      @(negedge clk);
    end
    check(leads == 0, "R5", leads, 0);
    check(highs == 0, "R5", highs, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1;
      nBad++;
      nChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    int hi, per, tr, s0, bad, sel, c, top;
    bit sp;
    void'($urandom(32'h1d2c));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(sclkV == 3'b0 && leadV == 3'b0 && trailV == 3'b0 && errV == 3'b0,
          "R10", int'({sclkV, leadV}), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    // R9 idle while disabled
    check(sclkV == 3'b0 && leadV == 3'b0, "R9", int'(sclkV), 0);
    enable = 1'b1;

    // R1 full ladder sweep
    for (int k = 2; k <= 18; k++) legalCase(0, k, 1'b0, "R1");
    // R2 binary sweep, special input toggled
    for (int k = 0; k < 8; k++) legalCase(2, k, k[0], "R2");
    // R6 divide by three
    legalCase(0, 1, 1'b1, "R6");
    reservedCase(0, 1, 1'b0, "R6");
    legalCase(0, 3, 1'b0, "R11");
    // R5 code zero then recovery
    reservedCase(0, 0, 1'b1, "R5");
    legalCase(0, 2, 1'b0, "R11");
    // R7 limits
    reservedCase(1, 17, 1'b0, "R7");
    reservedCase(0, 19, 1'b0, "R7");
    legalCase(1, 16, 1'b0, "R7");
    legalCase(0, 18, 1'b0, "R7");

    // R8 change mid-period
    legalCase(0, 4, 1'b0, "R8");
    setCode(0, 6);
    measure(0, hi, per, tr);
    check(per == 8, "R8", per, 8);
    measure(0, hi, per, tr);
    check(per == 16, "R8", per, 16);

    // R9 pause inside a period
    legalCase(0, 5, 1'b0, "R9");
    per = 0; bad = 0;
    repeat (3) begin per++; @(negedge clk); end
    enable = 1'b0;
    s0 = int'(sclkV[0]);
    repeat (10) begin
      per++;
      @(negedge clk);
      if (int'(sclkV[0]) != s0 || leadV[0] || trailV[0]) bad++;
    end
    enable = 1'b1;
    while (!leadV[0] && per < 3000) begin per++; @(negedge clk); end
    check(bad == 0, "R9", bad, 0);
    check(per == 22, "R9", per, 22);

    // random mix
    for (int n = 0; n < 30; n++) begin
      sel = int'($urandom % 3);
      sp = 1'($urandom);
      top = (sel == 2) ? 6 : 14;
      c = int'($urandom_range(0, top));
      if (sel == 1 && $urandom % 4 == 0) c = 17;
      if (expRatio(sel, c, sp) == 0) begin
        reservedCase(sel, c, sp, (c == 0) ? "R5" : (c == 1) ? "R6" : "R7");
        legalCase(sel, 2, sp, "R11");
      end else begin
        legalCase(sel, c, sp, (sel == 2) ? "R2" : "R1");
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule